// File: doc/BRIEF.md
# Palette-mapped pixel scanout unit

This block converts packed framebuffer words into 12-bit RGB pixels for a 640x400 display at four bits per pixel. An external timing generator supplies the beam coordinates and a pixel enable. For each active pixel that opens a new 32-bit word, the block computes the linear word address and issues a read on the framebuffer's scanout port. It then steps through the eight 4-bit colour indices of that word, leftmost pixel first. Each index is looked up in a 16-slot colour table, and the resulting RGB leaves the block together with a pixel-valid qualifier and a vertical-blank flag.

The framebuffer port is assumed to have a one-clock registered read. The returned word is forwarded straight to the index selector in the cycle it arrives, so a new word never leaves a hole in the pixel stream, even when the pixel enable is high on every clock. The colour table has one write port for the host side and an asynchronous read port for scanout.

Top module: `pixel_scanout`

## Requirements
- R1: While rst_ni is low and after its release, r_o, g_o, b_o, pix_valid_o, vblank_o and fb_rd_o are 0, and every colour-table slot holds 0.
- R2: fb_rd_o is high exactly when pix_en_i is high, x_i < 640, y_i < 400 and x_i mod 8 = 0. In that cycle fb_addr_o = y_i*80 + x_i/8. fb_rd_o is low in every other cycle.
- R3: The pixel at x uses bits [31-4*(x mod 8) : 28-4*(x mod 8)] of its word, so bits 31:28 give the leftmost of the eight pixels and bits 3:0 the rightmost.
- R4: The colour of an active pixel is the 12-bit slot selected by its index, split as r_o = slot[11:8], g_o = slot[7:4] and b_o = slot[3:0].
- R5: For a coordinate with x >= 640 or y >= 400, pix_valid_o is 0 and r_o, g_o, b_o are all 0. For an active coordinate, pix_valid_o is 1.
- R6: A write with pal_we_i high stores pal_wdata_i in slot pal_waddr_i at that clock edge. Every later lookup of that slot returns the new value.
- R7: vblank_o is 1 for a coordinate with y >= 400 and 0 otherwise. It is aligned with the pixel output of that same coordinate.
- R8: The outputs for the coordinate presented at pixel enable n appear just after the clock edge of pixel enable n+1. All outputs hold their values during clocks with pix_en_i low.
- R9: With pix_en_i high on every clock and a one-clock framebuffer read, pixels stay correct across word boundaries with no gap between the eighth pixel of one word and the first pixel of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel enable; advances the pipeline one pixel |
| x_i | input | 10 | Horizontal beam count |
| y_i | input | 10 | Vertical beam count |
| fb_rd_o | output | 1 | Framebuffer read request |
| fb_addr_o | output | 15 | Framebuffer word address |
| fb_data_i | input | 32 | Framebuffer read data, valid one clock after the request |
| pal_we_i | input | 1 | Colour table write enable |
| pal_waddr_i | input | 4 | Colour table slot to write |
| pal_wdata_i | input | 12 | Colour to store: red 11:8, green 7:4, blue 3:0 |
| r_o | output | 4 | Red intensity |
| g_o | output | 4 | Green intensity |
| b_o | output | 4 | Blue intensity |
| pix_valid_o | output | 1 | Output pixel lies in the active area |
| vblank_o | output | 1 | Output pixel lies in vertical blanking |

## Verification
The scan is first driven with a colour table still at its reset value, which separates the reset contents from the valid qualifier. After every slot is loaded with a distinct colour, the bench drives dense lines with an enable on every clock. These lines show whether the forwarded word reaches the first pixel of each word, and whether a wrong nibble order or a wrong line stride changes the colour. Lines with one or two idle clocks after every pixel check that the outputs hold between enables and that the captured word survives the idle clocks. Lines at the last active row and inside vertical blanking, plus a slot rewrite between lines, cover the blanking edge, the blank flag and the colour-table update.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
  localparam int CH_W = 4;
  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int H_ACTIVE     = 640,
  parameter int V_ACTIVE     = 400,
  parameter int PIX_PER_WORD = 8,
  parameter int X_W          = 10,
  parameter int Y_W          = 10,
  parameter int ADDR_W       = 15,
  parameter int SLOT_W       = 3
) (
  input  logic              pix_en_i,
  input  logic [X_W-1:0]    x_i,
  input  logic [Y_W-1:0]    y_i,
  output logic              active_o,
  output logic              vblank_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              fb_rd_o,
  output logic [ADDR_W-1:0] fb_addr_o
);
  localparam int WPL = H_ACTIVE / PIX_PER_WORD;
  localparam logic [X_W-1:0] H_LIM = X_W'(H_ACTIVE);
  localparam logic [Y_W-1:0] V_LIM = Y_W'(V_ACTIVE);

  always_comb begin
    active_o  = (x_i < H_LIM) && (y_i < V_LIM);
    vblank_o  = (y_i >= V_LIM);
    slot_o    = x_i[SLOT_W-1:0];
    fb_rd_o   = pix_en_i && active_o && (slot_o == '0);
    fb_addr_o = ADDR_W'(y_i) * ADDR_W'(WPL) + ADDR_W'(x_i >> SLOT_W);
  end
endmodule

// File: rtl/nibble_serializer.sv
module nibble_serializer #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic              active_i,
  input  logic              vblank_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              fb_rd_i,
  input  logic [WORD_W-1:0] fb_data_i,
  output logic              valid_o,
  output logic              vblank_o,
  output logic [PIX_W-1:0]  idx_o
);
  localparam int PPW = WORD_W / PIX_W;

  logic              valid_q, vblank_q, rd_pend_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] word_q, src;
  logic [PIX_W-1:0]  nibs [PPW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      vblank_q  <= 1'b0;
      slot_q    <= '0;
      rd_pend_q <= 1'b0;
      word_q    <= '0;
    end else begin
      rd_pend_q <= fb_rd_i;
      if (rd_pend_q) word_q <= fb_data_i;
      if (pix_en_i) begin
        valid_q  <= active_i;
        vblank_q <= vblank_i;
        slot_q   <= slot_i;
      end
    end
  end

  // forward the word in its arrival cycle so the first pixel has no bubble
  assign src = rd_pend_q ? fb_data_i : word_q;

  for (genvar g = 0; g < PPW; g++) begin : g_nib
    assign nibs[g] = src[WORD_W-1-g*PIX_W -: PIX_W];
  end

  assign idx_o    = nibs[slot_q];
  assign valid_o  = valid_q;
  assign vblank_o = vblank_q;

  assert_word_fetched_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pix_en_i) && valid_q && slot_q == '0) |-> rd_pend_q);
endmodule

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int IDX_W = 4,
  parameter int COL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [COL_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [COL_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COL_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_write_visible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && raddr_i == $past(waddr_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/pixel_scanout.sv
module pixel_scanout
  import scanout_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 400,
  parameter int X_W      = 10,
  parameter int Y_W      = 10,
  parameter int WORD_W   = 32,
  parameter int PIX_W    = 4,
  localparam int PPW     = WORD_W / PIX_W,
  localparam int SLOT_W  = $clog2(PPW),
  localparam int WPL     = H_ACTIVE / PPW,
  localparam int ADDR_W  = $clog2(WPL * V_ACTIVE),
  localparam int COL_W   = 3 * CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic [X_W-1:0]    x_i,
  input  logic [Y_W-1:0]    y_i,
  output logic              fb_rd_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic [WORD_W-1:0] fb_data_i,
  input  logic              pal_we_i,
  input  logic [PIX_W-1:0]  pal_waddr_i,
  input  logic [COL_W-1:0]  pal_wdata_i,
  output logic [CH_W-1:0]   r_o,
  output logic [CH_W-1:0]   g_o,
  output logic [CH_W-1:0]   b_o,
  output logic              pix_valid_o,
  output logic              vblank_o
);
  logic              active_s0, vblank_s0, valid_s1, vblank_s1;
  logic [SLOT_W-1:0] slot_s0;
  logic [PIX_W-1:0]  idx_s1;
  logic [COL_W-1:0]  pal_rd;
  rgb_t              rgb_q;
  logic              valid_q, vblank_q;

  scan_addr_gen #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .PIX_PER_WORD(PPW),
    .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) i_addr (
    .pix_en_i(pix_en_i), .x_i(x_i), .y_i(y_i),
    .active_o(active_s0), .vblank_o(vblank_s0), .slot_o(slot_s0),
    .fb_rd_o(fb_rd_o), .fb_addr_o(fb_addr_o)
  );

  nibble_serializer #(.WORD_W(WORD_W), .PIX_W(PIX_W), .SLOT_W(SLOT_W)) i_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i),
    .active_i(active_s0), .vblank_i(vblank_s0), .slot_i(slot_s0),
    .fb_rd_i(fb_rd_o), .fb_data_i(fb_data_i),
    .valid_o(valid_s1), .vblank_o(vblank_s1), .idx_o(idx_s1)
  );

  palette_ram #(.IDX_W(PIX_W), .COL_W(COL_W)) i_pal (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(pal_we_i), .waddr_i(pal_waddr_i), .wdata_i(pal_wdata_i),
    .raddr_i(idx_s1), .rdata_o(pal_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_q    <= '0;
      valid_q  <= 1'b0;
      vblank_q <= 1'b0;
    end else if (pix_en_i) begin
      rgb_q    <= valid_s1 ? rgb_t'(pal_rd) : '0;
      valid_q  <= valid_s1;
      vblank_q <= vblank_s1;
    end
  end

  assign r_o         = rgb_q.r;
  assign g_o         = rgb_q.g;
  assign b_o         = rgb_q.b;
  assign pix_valid_o = valid_q;
  assign vblank_o    = vblank_q;

  assert_blank_black_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> {r_o, g_o, b_o} == '0);
  assert_vblank_inactive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> !pix_valid_o);
  assert_addr_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> fb_addr_o < ADDR_W'(WPL * V_ACTIVE));
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable({r_o, g_o, b_o, pix_valid_o, vblank_o}));
endmodule

// File: tb/test_pixel_scanout.sv
`timescale 1ns/1ps
module test_pixel_scanout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [9:0]  x = '0, y = '0;
  logic        fb_rd;
  logic [14:0] fb_addr;
  logic [31:0] fb_data = '0;
  logic        we = 1'b0;
  logic [3:0]  wa = '0;
  logic [11:0] wd = '0;
  logic [3:0]  r, g, b;
  logic        valid, vblank;

  int vectors = 0, fails = 0;
  bit done = 0;
  string ph = "R1";

  logic [11:0] pal_m [16];
  int          q [$];
  logic [11:0] exp_rgb = '0;
  logic        exp_valid = 1'b0, exp_vb = 1'b0;

  always #2 clk = ~clk;

  pixel_scanout i_pixel_scanout (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(en), .x_i(x), .y_i(y),
    .fb_rd_o(fb_rd), .fb_addr_o(fb_addr), .fb_data_i(fb_data),
    .pal_we_i(we), .pal_waddr_i(wa), .pal_wdata_i(wd),
    .r_o(r), .g_o(g), .b_o(b), .pix_valid_o(valid), .vblank_o(vblank)
  );

  function automatic logic [31:0] memf(int a);
    logic [31:0] v;
    v = 32'(a) * 32'h9E3779B1;
    return v ^ (32'(a) << 7) ^ 32'h5A5A0F0F;
  endfunction

  // one-clock registered framebuffer
  always @(posedge clk) if (fb_rd) fb_data <= memf(int'(fb_addr));

  // reference: output after enable n+1 reflects the coordinate of enable n
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_rgb = '0; exp_valid = 1'b0; exp_vb = 1'b0;
      for (int i = 0; i < 16; i++) pal_m[i] = '0;
    end else begin
      if (en) begin
        if (q.size() > 0) begin
          int e, ex, ey;
          e = q.pop_front();
          ex = e / 1024; ey = e % 1024;
          exp_valid = (ex < 640) && (ey < 400);
          exp_vb = (ey >= 400);
          if (exp_valid) begin
            logic [31:0] w;
            int n;
            w = memf(ey * 80 + ex / 8);
            n = int'((w >> (28 - 4 * (ex % 8))) & 32'hF);
            exp_rgb = pal_m[n];
          end else exp_rgb = '0;
        end
        q.push_back(int'(x) * 1024 + int'(y));
      end
      if (we) pal_m[wa] = wd;
    end
  end

  task automatic chk(string what, int act, int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (x=%0d y=%0d)", ph, what, act, expv, x, y);
    end
  endtask

  // check at the falling edge, then drive the next inputs from the same process
  task automatic cyc(bit e, int nx, int ny, bit w = 0, int a = 0, int d = 0);
    @(negedge clk);
    chk("R4 rgb", int'({r, g, b}), int'(exp_valid ? exp_rgb : 12'h0));
    chk("R5 valid", int'(valid), int'(exp_valid));
    chk("R7 vblank", int'(vblank), int'(exp_vb));
    begin
      bit er;
      er = en && (x < 640) && (y < 400) && (x % 8 == 0);
      chk("R2 rd", int'(fb_rd), int'(er));
      if (er) chk("R2 addr", int'(fb_addr), int'(y) * 80 + int'(x) / 8);
    end
    en = e; x = 10'(nx); y = 10'(ny);
    we = w; wa = 4'(a); wd = 12'(d);
  endtask

  task automatic line(int ly, int gap);
    for (int px = 0; px < 800; px++) begin
      cyc(1, px, ly);
      for (int k = 0; k < gap; k++) cyc(0, px, ly);
    end
    cyc(0, 0, ly);
    cyc(0, 0, ly);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    // R6: reset colour table gives black while valid stays high (R5)
    ph = "R6 reset-table";
    line(3, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, i, (i * 273) ^ 12'hA5C);
    cyc(0, 0, 0);
    // R3 R9: dense enable, forwarded word at every boundary
    ph = "R3 R9 dense";
    line(0, 0);
    line(1, 0);
    line(2, 0);
    // R8: outputs hold across idle clocks
    ph = "R8 sparse";
    line(199, 1);
    line(5, 2);
    // R5 R7: last active row, then blanking rows
    ph = "R5 R7 edge";
    line(399, 0);
    line(400, 0);
    line(449, 1);
    // R6: rewrite slots between lines
    ph = "R6 rewrite";
    cyc(0, 0, 0, 1, 3, 12'h123);
    cyc(0, 0, 0, 1, 12, 12'hFED);
    cyc(0, 0, 0);
    line(7, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule